// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits in the command path of an SDRAM controller. It keeps the burst part of the mode register (burst length, burst type and CAS latency) and turns each read or write command into the series of column addresses that the burst covers, one address per clock. For reads it also raises a strobe in the cycles where read data returns, which is a fixed number of clocks after each column is issued.

A mode-register-set strobe loads the three settings from a 12-bit address key. A start strobe supplies the address bus of a read or write command. The block forms an 11-bit column from it, leaving out address bit 10. It then walks the burst in sequential or interleaved order, or runs a full-page burst that wraps over every column until a terminate strobe arrives. All inputs are sampled on the rising clock edge.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, `burst_busy`, `rd_valid` and `col_out` are all zero. The settings start as burst length 1, sequential, CAS latency 3.
- R2: A `mrs_load` cycle loads three fields from `mrs_key`. Bits 2:0 give the burst length (000=1, 001=2, 010=4, 011=8, 111=full page). Bit 3 gives the type (0 sequential, 1 interleaved). Bits 6:4 give the CAS latency (010=2, 011=3).
- R3: A length or latency code that is not listed in R2 leaves that field at its previous value. The other fields of the same key still load.
- R4: The column is built as {A11, A9..A0}, so `col_out[10]` comes from key bit 11. Address bit 10 has no effect on the column.
- R5: The first column appears on `col_out` in the cycle after `cmd_start` is sampled. Each later clock shows the next column. `burst_busy` stays high for exactly as many cycles as the burst length.
- R6: In a sequential burst of length BL, the low log2(BL) column bits count up from the start value and wrap. The upper bits stay fixed.
- R7: In an interleaved burst, the low log2(BL) bits of beat k are the start bits XOR k. The upper bits stay fixed.
- R8: A full-page burst counts up through all 2048 columns, wrapping from 0x7FF to 0x000, until it is stopped. The type bit is ignored for full-page bursts.
- R9: When `burst_stop` is sampled during a burst, `burst_busy` is low in the following cycle. When the block is idle, `burst_stop` has no effect.
- R10: If `cmd_start` is sampled during a burst, the old burst ends and the next cycle shows beat 0 of the new burst.
- R11: For a read, `rd_valid` is high in the cycle that comes CAS-latency cycles after each cycle in which a column was shown. This holds across back-to-back bursts. A write never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mrs_load | input | 1 | Load the burst settings from `mrs_key` |
| mrs_key | input | 12 | Address key for the mode-register-set command |
| cmd_start | input | 1 | Start a burst |
| cmd_is_read | input | 1 | 1 for a read command, 0 for a write |
| cmd_addr | input | 12 | Address bus of the command, which carries the start column |
| burst_stop | input | 1 | Terminate the running burst |
| col_out | output | 11 | Column address of the current beat |
| burst_busy | output | 1 | A burst beat is being shown on `col_out` |
| rd_valid | output | 1 | Read data is expected in this cycle |

## Verification
The assertions assume that the CAS latency setting does not change while read beats are still in the return pipeline. Under that assumption, every `rd_valid` can be matched to an earlier read beat. They also assume that no more than one command strobe is present in a cycle, apart from the defined pairing of start with stop. The stimulus loads the mode register only when the block is idle and the pipeline has drained. It never raises `mrs_load` together with `cmd_start`. Its one start-during-burst case uses reads on both sides, so that rd_valid continuity can be checked.

// File: rtl/sdram_burst_pkg.sv
// Package: shared types and field positions for the burst column sequencer.
// Assumes the mode key is at least 7 bits wide, which covers all three fields.
package sdram_burst_pkg;

    // Field positions inside the mode-register key.
    localparam int unsigned LEN_LSB  = 0;
    localparam int unsigned TYPE_BIT = 3;
    localparam int unsigned LAT_LSB  = 4;

    typedef enum logic [2:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } blen_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } border_e;

    typedef struct packed {
        blen_e      blen;
        border_e    order;
        logic [1:0] lat;   // 2 or 3
    } burst_mode_t;

    // Wrap mask of a fixed-length burst (full page is handled apart).
    function automatic logic [2:0] len_mask(input blen_e b);
        case (b)
            LEN_2:   len_mask = 3'b001;
            LEN_4:   len_mask = 3'b011;
            LEN_8:   len_mask = 3'b111;
            default: len_mask = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
// Module: sdram_mode_reg
// Holds the burst settings and updates them field by field on a load strobe.
// A length or latency code that is not supported leaves that field unchanged.
// Assumes KEY_W >= 7.
module sdram_mode_reg
    import sdram_burst_pkg::*;
#(
    parameter int unsigned KEY_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [KEY_W-1:0] key,
    output burst_mode_t mode
);

    logic [2:0] len_code;
    logic [2:0] lat_code;
    logic       len_ok;
    logic       lat_ok;
    logic [1:0] lat_new;

    assign len_code = key[LEN_LSB +: 3];
    assign lat_code = key[LAT_LSB +: 3];

    // Decode whether the length and latency codes are supported.
    always_comb begin
        len_ok  = 1'b0;
        lat_ok  = 1'b0;
        lat_new = 2'd3;
        case (len_code)
            3'b000, 3'b001, 3'b010, 3'b011, 3'b111: len_ok = 1'b1;
            default:                                len_ok = 1'b0;
        endcase
        case (lat_code)
            3'b010:  begin lat_ok = 1'b1; lat_new = 2'd2; end
            3'b011:  begin lat_ok = 1'b1; lat_new = 2'd3; end
            default: begin lat_ok = 1'b0; lat_new = 2'd3; end
        endcase
    end

    // Register the fields, each one kept when its code is reserved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode.blen  <= LEN_1;
            mode.order <= ORD_SEQ;
            mode.lat   <= 2'd3;
        end else if (load) begin
            if (len_ok) begin
                mode.blen <= blen_e'(len_code);
            end
            mode.order <= border_e'(key[TYPE_BIT]);
            if (lat_ok) begin
                mode.lat <= lat_new;
            end
        end
    end

endmodule

// File: rtl/sdram_col_extract.sv
// Module: sdram_col_extract
// Drops one address bit (SKIP_BIT) and packs the rest into a column number.
// Assumes SKIP_BIT < ADDR_W; purely combinational.
module sdram_col_extract #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned SKIP_BIT = 10,
    localparam int unsigned COL_W   = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  col
);

    // Choose the packing that matches where the skipped bit sits.
    generate
        if (SKIP_BIT == 0) begin : g_skip_low
            assign col = addr[ADDR_W-1:1];
        end else if (SKIP_BIT == ADDR_W - 1) begin : g_skip_high
            assign col = addr[ADDR_W-2:0];
        end else begin : g_skip_mid
            assign col = {addr[ADDR_W-1:SKIP_BIT+1], addr[SKIP_BIT-1:0]};
        end
    endgenerate

endmodule

// File: rtl/sdram_burst_ctl.sv
// Module: sdram_burst_ctl
// Runs one burst: latches the start column and settings, counts beats,
// forms the column in sequential, interleaved or full-page order and
// ends on the last beat or on a stop strobe. A start always wins.
// Assumes COL_W >= 4.
module sdram_burst_ctl
    import sdram_burst_pkg::*;
#(
    parameter int unsigned COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_rd,
    input  logic             stop,
    input  burst_mode_t      mode,
    output logic [COL_W-1:0] col,
    output logic             busy,
    output logic             rd_issue,
    output logic             page_mode
);

    logic             active_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [2:0]       low_q;
    logic             page_q;
    logic             ilv_q;
    logic             rd_q;
    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] step_seq;
    logic [COL_W-1:0] step_ilv;
    logic             last_beat;

    // Wrap mask: the whole column for a full page, else the low bits.
    assign wrap_mask = page_q ? {COL_W{1'b1}} : {{(COL_W-3){1'b0}}, low_q};

    // Form both orderings and keep the bits above the mask.
    always_comb begin
        step_seq = (base_q & ~wrap_mask) | ((base_q + beat_q) & wrap_mask);
        step_ilv = (base_q & ~wrap_mask) | ((base_q ^ beat_q) & wrap_mask);
        col      = ilv_q ? step_ilv : step_seq;
    end

    assign last_beat = !page_q && (beat_q == wrap_mask);

    // Latch the burst parameters when a command starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            low_q  <= 3'b000;
            page_q <= 1'b0;
            ilv_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            low_q  <= len_mask(mode.blen);
            page_q <= (mode.blen == LEN_PAGE);
            ilv_q  <= (mode.order == ORD_ILV) && (mode.blen != LEN_PAGE);
            rd_q   <= start_rd;
        end
    end

    // Advance the beat counter and end the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            beat_q   <= '0;
        end else if (active_q) begin
            if (stop || last_beat) begin
                active_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign busy      = active_q;
    assign rd_issue  = active_q && rd_q;
    assign page_mode = active_q && page_q;

endmodule

// File: rtl/sdram_rdv_pipe.sv
// Module: sdram_rdv_pipe
// Delays the read-beat flag by the programmed CAS latency through a shift
// register of depth MAX_LAT and taps the stage that matches the latency.
// Assumes the latency is between 1 and MAX_LAT, and stable while beats are in flight.
module sdram_rdv_pipe #(
    parameter int unsigned MAX_LAT = 3,
    parameter int unsigned LAT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [LAT_W-1:0] lat,
    output logic             valid
);

    logic [MAX_LAT-1:0] stage_q;

    // Shift one flag per clock so that back-to-back beats stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[MAX_LAT-2:0], issue};
        end
    end

    // Tap the stage that is lat cycles behind the issue.
    always_comb begin
        valid = 1'b0;
        for (int i = 0; i < MAX_LAT; i++) begin
            if (LAT_W'(i + 1) == lat) begin
                valid = stage_q[i];
            end
        end
    end

endmodule

// File: rtl/sdram_burst_seq.sv
// Module: sdram_burst_seq (top)
// Ties the mode register, column extraction, burst control and read-valid
// pipeline together. Assumes the mode register is loaded only when no read
// beats are pending, and never together with a start strobe.
module sdram_burst_seq
    import sdram_burst_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned SKIP_BIT = 10,
    parameter int unsigned MAX_LAT  = 3,
    localparam int unsigned COL_W   = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_load,
    input  logic [ADDR_W-1:0] mrs_key,
    input  logic              cmd_start,
    input  logic              cmd_is_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              burst_stop,
    output logic [COL_W-1:0]  col_out,
    output logic              burst_busy,
    output logic              rd_valid
);

    burst_mode_t      mode;
    logic [COL_W-1:0] start_col;
    logic             rd_issue;
    logic             page_act;

    sdram_mode_reg #(.KEY_W(ADDR_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mrs_load),
        .key   (mrs_key),
        .mode  (mode)
    );

    sdram_col_extract #(.ADDR_W(ADDR_W), .SKIP_BIT(SKIP_BIT)) u_colx (
        .addr (cmd_addr),
        .col  (start_col)
    );

    sdram_burst_ctl #(.COL_W(COL_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .start_col (start_col),
        .start_rd  (cmd_is_read),
        .stop      (burst_stop),
        .mode      (mode),
        .col       (col_out),
        .busy      (burst_busy),
        .rd_issue  (rd_issue),
        .page_mode (page_act)
    );

    sdram_rdv_pipe #(.MAX_LAT(MAX_LAT), .LAT_W(2)) u_rdv (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (rd_issue),
        .lat   (mode.lat),
        .valid (rd_valid)
    );

endmodule

// File: rtl/sdram_burst_seq_chk.sv
// Module: sdram_burst_seq_chk
// Checker bound to the top. Assumes the CAS latency is not changed while
// read beats are pending.
module sdram_burst_seq_chk #(
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned COL_W = ADDR_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              burst_stop,
    input logic [COL_W-1:0]  col_out,
    input logic              burst_busy,
    input logic              rd_valid,
    input logic              rd_issue,
    input logic              page_act
);

    int unsigned pend_q;

    // Track read beats that have not yet had their valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 0;
        end else begin
            pend_q <= pend_q + (rd_issue ? 1 : 0) - (rd_valid ? 1 : 0);
        end
    end

    // R5: without a start, an idle block stays idle.
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_busy && !cmd_start) |=> !burst_busy);

    // R10: a start shows beat 0 of the new burst, built from A11 and A9..A0 (R4).
    a_r10_start_col: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (burst_busy &&
            col_out == {$past(cmd_addr[ADDR_W-1]), $past(cmd_addr[COL_W-2:0])}));

    // R9: a stop without a start ends the burst.
    a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !cmd_start) |=> !burst_busy);

    // R8: a full-page burst steps the column by one each cycle.
    a_r8_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (page_act && !cmd_start && !burst_stop) |=>
            (burst_busy && col_out == $past(col_out) + 1'b1));

    // R11: every read-valid cycle belongs to an earlier read beat.
    a_r11_valid_owned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (pend_q != 0));

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_addr   (cmd_addr),
    .burst_stop (burst_stop),
    .col_out    (col_out),
    .burst_busy (burst_busy),
    .rd_valid   (rd_valid),
    .rd_issue   (rd_issue),
    .page_act   (page_act)
);

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mrs_load = 1'b0;
    logic [11:0] mrs_key = '0;
    logic        cmd_start = 1'b0;
    logic        cmd_is_read = 1'b0;
    logic [11:0] cmd_addr = '0;
    logic        burst_stop = 1'b0;
    logic [10:0] col_out;
    logic        burst_busy;
    logic        rd_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    sdram_burst_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mrs_load    (mrs_load),
        .mrs_key     (mrs_key),
        .cmd_start   (cmd_start),
        .cmd_is_read (cmd_is_read),
        .cmd_addr    (cmd_addr),
        .burst_stop  (burst_stop),
        .col_out     (col_out),
        .burst_busy  (burst_busy),
        .rd_valid    (rd_valid)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got=%0h exp=%0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Expected column of beat k; blen 0 stands for a full page.
    function automatic logic [10:0] exp_col(input logic [10:0] s, input int k,
                                            input int blen, input bit ilv);
        logic [10:0] m;
        logic [10:0] kk;
        kk = 11'(k);
        if (blen == 0) return s + kk;
        m = 11'(blen - 1);
        if (ilv) return (s & ~m) | ((s ^ kk) & m);
        return (s & ~m) | ((s + kk) & m);
    endfunction

    task automatic mrs(input logic [11:0] key);
        @(negedge clk);
        mrs_load = 1'b1;
        mrs_key  = key;
        @(negedge clk);
        mrs_load = 1'b0;
        @(negedge clk);
    endtask

    // Start one burst and check busy, columns and read-valid cycle by cycle.
    task automatic run_plain(input string req, input logic [11:0] addr,
                             input logic [10:0] scol, input bit rd,
                             input int blen, input bit ilv, input int cl);
        @(negedge clk);
        cmd_start   = 1'b1;
        cmd_addr    = addr;
        cmd_is_read = rd;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int j = 0; j < blen + cl + 2; j++) begin
            chk(req, "busy", 32'(burst_busy), 32'(j < blen));
            if (j < blen) chk(req, "col", 32'(col_out), 32'(exp_col(scol, j, blen, ilv)));
            chk(req, "rd_valid", 32'(rd_valid),
                32'(rd && j >= cl && (j - cl) < blen));
            @(negedge clk);
        end
    endtask

    // R1: state after reset.
    task automatic t_reset;
        chk("R1", "busy", 32'(burst_busy), 0);
        chk("R1", "rd_valid", 32'(rd_valid), 0);
        chk("R1", "col", 32'(col_out), 0);
    endtask

    // R1/R5/R11: default settings give one beat and latency 3.
    task automatic t_default;
        run_plain("R1", 12'h123, 11'h123, 1'b1, 1, 1'b0, 3);
    endtask

    // R2/R6/R11: BL4 sequential, CAS 2, read then write.
    task automatic t_seq4;
        mrs(12'h022);
        run_plain("R6", 12'h006, 11'h006, 1'b1, 4, 1'b0, 2);
        run_plain("R2", 12'h43B, 11'h03B, 1'b0, 4, 1'b0, 2);
    endtask

    // R7: BL8 interleaved.
    task automatic t_ilv8;
        mrs(12'h02B);
        run_plain("R7", 12'h0D5, 11'h0D5, 1'b1, 8, 1'b1, 2);
    endtask

    // R3: reserved length and latency codes keep BL8 and CAS 2.
    task automatic t_reserved;
        mrs(12'h05C);
        run_plain("R3", 12'h0D5, 11'h0D5, 1'b1, 8, 1'b1, 2);
    endtask

    // R4: A11 goes to column bit 10 and A10 is dropped.
    task automatic t_colbits;
        mrs(12'h030);
        run_plain("R4", 12'hFFF, 11'h7FF, 1'b1, 1, 1'b0, 3);
        run_plain("R4", 12'h3FF, 11'h3FF, 1'b0, 1, 1'b0, 3);
        run_plain("R4", 12'h800, 11'h400, 1'b0, 1, 1'b0, 3);
    endtask

    // R8/R9: full page, type bit ignored, wraps, stops on request.
    task automatic t_fullpage;
        mrs(12'h02F);
        @(negedge clk);
        cmd_start   = 1'b1;
        cmd_addr    = 12'hBFE;
        cmd_is_read = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int j = 0; j < 6; j++) begin
            chk("R8", "busy", 32'(burst_busy), 1);
            chk("R8", "col", 32'(col_out), 32'(11'(11'h7FE + 11'(j))));
            chk("R11", "rd_valid write", 32'(rd_valid), 0);
            if (j == 5) burst_stop = 1'b1;
            @(negedge clk);
        end
        burst_stop = 1'b0;
        chk("R9", "busy after stop", 32'(burst_busy), 0);
        chk("R9", "col held", 32'(col_out), 32'(11'h003));
    endtask

    // R9: stop while idle does nothing.
    task automatic t_stop_idle;
        @(negedge clk);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        chk("R9", "idle busy", 32'(burst_busy), 0);
        chk("R9", "idle col", 32'(col_out), 32'(11'h003));
        chk("R9", "idle rd_valid", 32'(rd_valid), 0);
    endtask

    // R10/R11: restart mid-burst, reads back to back, BL8 seq CAS 2.
    task automatic t_restart;
        logic [10:0] e;
        mrs(12'h023);
        @(negedge clk);
        cmd_start   = 1'b1;
        cmd_addr    = 12'h010;
        cmd_is_read = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int j = 0; j < 14; j++) begin
            if (j < 3) e = exp_col(11'h010, j, 8, 1'b0);
            else       e = exp_col(11'h020, j - 3, 8, 1'b0);
            chk("R10", "busy", 32'(burst_busy), 32'(j < 11));
            if (j < 11) chk("R10", "col", 32'(col_out), 32'(e));
            chk("R11", "rd_valid b2b", 32'(rd_valid), 32'(j >= 2 && j <= 12));
            if (j == 2) begin
                cmd_start = 1'b1;
                cmd_addr  = 12'h020;
            end
            @(negedge clk);
            cmd_start = 1'b0;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL R5 watchdog expired got=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_default;
        t_seq4;
        t_ilv8;
        t_reserved;
        t_colbits;
        t_fullpage;
        t_stop_idle;
        t_restart;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule